// File: doc/BRIEF.md
# Edge-Detecting GPIO Controller

A memory-mapped general-purpose I/O controller for 28 pins. It sits behind a plain 32-bit register port: one address, one write strobe, write data and combinational read data. Software picks, pin by pin, whether the pin is driven. It moves the output latch through two write-one registers, one that raises bits and one that lowers them, so no read-modify-write is needed. It reads the present level of every pin from a single register.

Each pin input passes through a two-stage synchroniser. The synchronised value is compared with its value one cycle earlier to find edges. Separate rising and falling enables choose which transitions are recorded in a sticky status register, which software clears by writing ones. Pins 0 to 10 each own an interrupt line that follows their status bit. Pins 11 to 27 share a single line that is high while any of their status bits is set. A further 32-bit register is plain storage for a neighbouring pin-multiplexing block.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset the direction, output latch, both edge-enable, status and spare registers read zero, and `pin_oe`, `pin_out`, `irq_pin` and `irq_group` are all low.
- R2: The direction register at byte address 0x04 reads back what was written. A 1 in bit i makes pin i an output (`pin_oe[i]` high) and a 0 makes it an input, from the cycle after the write.
- R3: Writing to 0x08 sets every latch bit whose data bit is 1, and writing to 0x0C clears every latch bit whose data bit is 1. Zero bits leave the latch alone. `pin_out` shows the latch from the cycle after the write, and both addresses read as zero.
- R4: Address 0x00 returns the pin levels. For an output pin this is the latch bit. For an input pin it is `pin_in` after two clock edges of synchronisation. Writes to 0x00 change nothing.
- R5: With bit i of the rising-enable register (0x10) set, a 0-to-1 change on `pin_in[i]` sets status bit i (register 0x18). The bit is readable after the third rising clock edge that follows the change.
- R6: With bit i of the falling-enable register (0x14) set, a 1-to-0 change sets status bit i with the same latency. With both enables set, either change sets it. With neither set, no change sets it.
- R7: Status bits stay set until software writes a 1 to them at 0x18. Zero bits in that write leave the status untouched.
- R8: If an enabled edge on pin i arrives in the same cycle as a write of 1 to status bit i, the bit stays set.
- R9: `irq_pin[i]` (i = 0..10) is high exactly while status bit i is set. `irq_group` is high exactly while any of status bits 11..27 is set.
- R10: Address 0x1C is a 32-bit read/write register with no effect on the pins or the edge logic.
- R11: An access whose two low address bits are not zero writes nothing and reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pin_in | input | 28 | Asynchronous pin levels |
| pin_out | output | 28 | Output latch |
| pin_oe | output | 28 | Per-pin output enable (direction) |
| irq_pin | output | 11 | Interrupt lines for pins 0 to 10 |
| irq_group | output | 1 | Shared interrupt for pins 11 to 27 |

## Verification
Register writes take effect on the clock edge that samples the strobe, so the bench checks `pin_oe`, `pin_out` and read-back at the following falling edge. A level change on `pin_in` reaches the level register after two rising edges. It reaches the status register and the interrupt lines after three. Every pin-driven check therefore waits exactly that many edges after the falling edge on which the bench moved the pin. The simultaneous edge-and-clear case is built by placing the clearing write strobe on the third edge after the pin change, the edge on which the status flop captures the event.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int GP_PINS   = 28;
    localparam int GP_DIRECT = 11;
    localparam int GP_DATA_W = 32;
    localparam int GP_ADDR_W = 5;

    // Register select taken from the word index of the byte address.
    typedef enum logic [2:0] {
        SEL_LEVEL = 3'd0,
        SEL_DIR   = 3'd1,
        SEL_SET   = 3'd2,
        SEL_CLR   = 3'd3,
        SEL_RISE  = 3'd4,
        SEL_FALL  = 3'd5,
        SEL_STAT  = 3'd6,
        SEL_SPARE = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic     valid;   // word-aligned access
        logic     wr;      // write strobe qualified by alignment
        reg_sel_e sel;
    } bus_cmd_t;

    function automatic bus_cmd_t decode_cmd(input logic [GP_ADDR_W-1:0] addr,
                                            input logic                 we);
        bus_cmd_t c;
        c.valid = (addr[1:0] == 2'b00);
        c.wr    = we && c.valid;
        c.sel   = reg_sel_e'(addr[4:2]);
        return c;
    endfunction

    function automatic logic wr_to(input bus_cmd_t c, input reg_sel_e s);
        return c.wr && (c.sel == s);
    endfunction

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
    parameter int WIDTH = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_lvl,
    output logic [WIDTH-1:0] rise_ev,
    output logic [WIDTH-1:0] fall_ev
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign sync_lvl = sync_q;
    assign rise_ev  = sync_q & ~prev_q;
    assign fall_ev  = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
    parameter int WIDTH      = 28,
    parameter int NUM_DIRECT = 11
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [WIDTH-1:0]      rise_ev,
    input  logic [WIDTH-1:0]      fall_ev,
    input  logic [WIDTH-1:0]      rise_en,
    input  logic [WIDTH-1:0]      fall_en,
    input  logic                  clr_we,
    input  logic [WIDTH-1:0]      clr_mask,
    output logic [WIDTH-1:0]      stat,
    output logic [NUM_DIRECT-1:0] irq_direct,
    output logic                  irq_group
);
    localparam int GROUP_LO = NUM_DIRECT;

    logic [WIDTH-1:0] hit;
    logic [WIDTH-1:0] stat_q;

    assign hit = (rise_ev & rise_en) | (fall_ev & fall_en);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // A fresh event wins over a same-cycle clear.
        always_ff @(posedge clk) begin
            if (rst)
                stat_q[i] <= 1'b0;
            else
                stat_q[i] <= (stat_q[i] & ~(clr_we & clr_mask[i])) | hit[i];
        end
    end

    for (genvar j = 0; j < NUM_DIRECT; j++) begin : g_direct
        assign irq_direct[j] = stat_q[j];
    end

    assign irq_group = |stat_q[WIDTH-1:GROUP_LO];
    assign stat      = stat_q;
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PINS   = GP_PINS,
    parameter int NUM_DIRECT = GP_DIRECT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [GP_ADDR_W-1:0]  bus_addr,
    input  logic                  bus_we,
    input  logic [GP_DATA_W-1:0]  bus_wdata,
    output logic [GP_DATA_W-1:0]  bus_rdata,
    input  logic [NUM_PINS-1:0]   pin_in,
    output logic [NUM_PINS-1:0]   pin_out,
    output logic [NUM_PINS-1:0]   pin_oe,
    output logic [NUM_DIRECT-1:0] irq_pin,
    output logic                  irq_group
);
    bus_cmd_t cmd;
    assign cmd = decode_cmd(bus_addr, bus_we);

    logic [NUM_PINS-1:0]  wd;
    assign wd = bus_wdata[NUM_PINS-1:0];

    logic [NUM_PINS-1:0]  dir_q;
    logic [NUM_PINS-1:0]  latch_q;
    logic [NUM_PINS-1:0]  rise_en_q;
    logic [NUM_PINS-1:0]  fall_en_q;
    logic [GP_DATA_W-1:0] spare_q;

    logic [NUM_PINS-1:0]  pin_sync;
    logic [NUM_PINS-1:0]  pin_rise;
    logic [NUM_PINS-1:0]  pin_fall;
    logic [NUM_PINS-1:0]  edge_stat;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q     <= '0;
            latch_q   <= '0;
            rise_en_q <= '0;
            fall_en_q <= '0;
            spare_q   <= '0;
        end else begin
            if (wr_to(cmd, SEL_DIR))   dir_q     <= wd;
            if (wr_to(cmd, SEL_SET))   latch_q   <= latch_q | wd;
            if (wr_to(cmd, SEL_CLR))   latch_q   <= latch_q & ~wd;
            if (wr_to(cmd, SEL_RISE))  rise_en_q <= wd;
            if (wr_to(cmd, SEL_FALL))  fall_en_q <= wd;
            if (wr_to(cmd, SEL_SPARE)) spare_q   <= bus_wdata;
        end
    end

    gpio_edge_sync #(.WIDTH(NUM_PINS)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .raw_in   (pin_in),
        .sync_lvl (pin_sync),
        .rise_ev  (pin_rise),
        .fall_ev  (pin_fall)
    );

    gpio_edge_status #(.WIDTH(NUM_PINS), .NUM_DIRECT(NUM_DIRECT)) status_i (
        .clk        (clk),
        .rst        (rst),
        .rise_ev    (pin_rise),
        .fall_ev    (pin_fall),
        .rise_en    (rise_en_q),
        .fall_en    (fall_en_q),
        .clr_we     (wr_to(cmd, SEL_STAT)),
        .clr_mask   (wd),
        .stat       (edge_stat),
        .irq_direct (irq_pin),
        .irq_group  (irq_group)
    );

    logic [NUM_PINS-1:0] level;
    assign level = (dir_q & latch_q) | (~dir_q & pin_sync);

    always_comb begin
        bus_rdata = '0;
        if (cmd.valid) begin
            unique case (cmd.sel)
                SEL_LEVEL: bus_rdata[NUM_PINS-1:0] = level;
                SEL_DIR:   bus_rdata[NUM_PINS-1:0] = dir_q;
                SEL_SET:   bus_rdata = '0;
                SEL_CLR:   bus_rdata = '0;
                SEL_RISE:  bus_rdata[NUM_PINS-1:0] = rise_en_q;
                SEL_FALL:  bus_rdata[NUM_PINS-1:0] = fall_en_q;
                SEL_STAT:  bus_rdata[NUM_PINS-1:0] = edge_stat;
                SEL_SPARE: bus_rdata = spare_q;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign pin_out = latch_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PINS = GP_PINS
) (
    input logic                 clk,
    input logic                 rst,
    input logic [GP_ADDR_W-1:0] bus_addr,
    input logic                 bus_we,
    input logic [GP_DATA_W-1:0] bus_wdata,
    input logic [NUM_PINS-1:0]  pin_out,
    input logic [NUM_PINS-1:0]  pin_oe,
    input logic [NUM_PINS-1:0]  edge_stat
);
    localparam logic [GP_ADDR_W-1:0] A_DIR  = 5'h04;
    localparam logic [GP_ADDR_W-1:0] A_SET  = 5'h08;
    localparam logic [GP_ADDR_W-1:0] A_CLR  = 5'h0C;
    localparam logic [GP_ADDR_W-1:0] A_STAT = 5'h18;

    logic [NUM_PINS-1:0] wmask;
    assign wmask = bus_wdata[NUM_PINS-1:0];

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pin_oe == '0 && pin_out == '0 && edge_stat == '0));

    assert_dir_follows_write_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_DIR) |=> (pin_oe == $past(wmask)));

    assert_set_raises_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_SET) |=> ((pin_out & $past(wmask)) == $past(wmask)));

    assert_clear_lowers_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_CLR) |=> ((pin_out & $past(wmask)) == '0));

    assert_latch_holds_R3: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && (bus_addr == A_SET || bus_addr == A_CLR)) |=> $stable(pin_out));

    assert_status_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == A_STAT) |=> ((edge_stat & $past(edge_stat)) == $past(edge_stat)));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.NUM_PINS(NUM_PINS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .edge_stat (edge_stat)
);

// File: tb/gpio_edge_ctrl_tb_top.sv
module gpio_edge_ctrl_tb_top;
    localparam int NP = 28;
    localparam int ND = 11;
    localparam logic [NP-1:0] ALL = {NP{1'b1}};

    localparam logic [4:0] A_LEVEL = 5'h00;
    localparam logic [4:0] A_DIR   = 5'h04;
    localparam logic [4:0] A_SET   = 5'h08;
    localparam logic [4:0] A_CLR   = 5'h0C;
    localparam logic [4:0] A_RISE  = 5'h10;
    localparam logic [4:0] A_FALL  = 5'h14;
    localparam logic [4:0] A_STAT  = 5'h18;
    localparam logic [4:0] A_SPARE = 5'h1C;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [4:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic [ND-1:0] irq_pin;
    logic          irq_group;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_edge_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_pin(irq_pin), .irq_group(irq_group)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Ends on the falling edge after the write edge.
    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #2;
        d = bus_rdata;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_irqs(input string req, input logic [NP-1:0] st);
        check(req, {20'd0, irq_pin, irq_group}, {20'd0, st[ND-1:0], |st[NP-1:ND]});
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [NP-1:0] lat;
        logic [NP-1:0] dmask;
        logic [NP-1:0] exp_st;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        bus_read(A_DIR, rd);   check("R1 dir", rd, 0);
        bus_read(A_RISE, rd);  check("R1 rise_en", rd, 0);
        bus_read(A_FALL, rd);  check("R1 fall_en", rd, 0);
        bus_read(A_STAT, rd);  check("R1 status", rd, 0);
        bus_read(A_SPARE, rd); check("R1 spare", rd, 0);
        check("R1 pins", {4'd0, pin_out} | {4'd0, pin_oe}, 0);
        check("R1 irqs", {20'd0, irq_pin, irq_group}, 0);

        // R2: direction patterns
        foreach (dmask[k]) dmask[k] = 1'b0;
        for (int p = 0; p < 4; p++) begin
            logic [NP-1:0] pat;
            pat = NP'(32'h0A5A_5A5A * (p + 1) ^ (32'h0111_1111 << p));
            bus_write(A_DIR, {4'd0, pat});
            bus_read(A_DIR, rd);
            check("R2 dir readback", rd, {4'd0, pat});
            check("R2 pin_oe", {4'd0, pin_oe}, {4'd0, pat});
        end

        // R3: set/clear latch
        bus_write(A_DIR, {4'd0, ALL});
        lat = '0;
        bus_write(A_SET, 32'h0000_F00F); lat |= NP'(32'h0000_F00F);
        check("R3 set", {4'd0, pin_out}, {4'd0, lat});
        bus_write(A_SET, 32'h0F30_0100); lat |= NP'(32'h0F30_0100);
        check("R3 set accumulates", {4'd0, pin_out}, {4'd0, lat});
        bus_write(A_CLR, 32'h0010_000F); lat &= ~NP'(32'h0010_000F);
        check("R3 clear", {4'd0, pin_out}, {4'd0, lat});
        bus_write(A_CLR, 32'h0);
        check("R3 zero clear no effect", {4'd0, pin_out}, {4'd0, lat});
        bus_read(A_SET, rd); check("R3 set reads zero", rd, 0);
        bus_read(A_CLR, rd); check("R3 clr reads zero", rd, 0);

        // R4: level register mixes latch and synchronised input
        for (int p = 0; p < 3; p++) begin
            logic [NP-1:0] d, pv;
            d  = NP'(32'h0C3C_3C3C >> p);
            pv = NP'(32'h0ACE_1357 ^ (32'h0FFF_0000 >> (4 * p)));
            bus_write(A_DIR, {4'd0, d});
            pin_in = pv;
            wait_edges(2);
            bus_read(A_LEVEL, rd);
            check("R4 level", rd, {4'd0, (d & lat) | (~d & pv)});
            bus_write(A_LEVEL, 32'hFFFF_FFFF);
            bus_read(A_LEVEL, rd);
            check("R4 write ignored", rd, {4'd0, (d & lat) | (~d & pv)});
            check("R4 write ignored latch", {4'd0, pin_out}, {4'd0, lat});
        end
        pin_in = '0;
        bus_write(A_DIR, 32'h0);
        wait_edges(3);
        bus_write(A_STAT, 32'hFFFF_FFFF);

        // R5 R6 R9: sweep every pin and every enable mode
        for (int pin = 0; pin < NP; pin++) begin
            for (int mode = 0; mode < 4; mode++) begin
                logic [NP-1:0] b;
                b = NP'(1) << pin;
                bus_write(A_RISE, mode[0] ? {4'd0, b} : 32'h0);
                bus_write(A_FALL, mode[1] ? {4'd0, b} : 32'h0);
                pin_in = b;
                wait_edges(3);
                exp_st = mode[0] ? b : '0;
                bus_read(A_STAT, rd);
                check("R5 rising capture", rd, {4'd0, exp_st});
                check_irqs("R9 irq map rise", exp_st);
                bus_write(A_STAT, 32'hFFFF_FFFF);
                pin_in = '0;
                wait_edges(3);
                exp_st = mode[1] ? b : '0;
                bus_read(A_STAT, rd);
                check("R6 falling capture", rd, {4'd0, exp_st});
                check_irqs("R9 irq map fall", exp_st);
                bus_write(A_STAT, 32'hFFFF_FFFF);
            end
        end

        // R7: sticky, partial clear, zero write
        bus_write(A_RISE, {4'd0, ALL});
        bus_write(A_FALL, 32'h0);
        pin_in = NP'(32'h0010_0821);
        wait_edges(3);
        exp_st = NP'(32'h0010_0821);
        wait_edges(4);
        bus_read(A_STAT, rd); check("R7 sticky", rd, {4'd0, exp_st});
        bus_write(A_STAT, 32'h0000_0020); exp_st &= ~NP'(32'h20);
        bus_read(A_STAT, rd); check("R7 partial clear", rd, {4'd0, exp_st});
        check_irqs("R9 after partial clear", exp_st);
        bus_write(A_STAT, 32'h0);
        bus_read(A_STAT, rd); check("R7 zero write", rd, {4'd0, exp_st});
        bus_write(A_STAT, 32'hFFFF_FFFF);
        bus_read(A_STAT, rd); check("R7 clear all", rd, 0);
        check_irqs("R9 all clear", '0);

        // R8: edge coincides with clear
        bus_write(A_FALL, {4'd0, ALL});
        pin_in = NP'(32'h0010_0829);           // rise on pin 3
        wait_edges(3);
        bus_read(A_STAT, rd); check("R8 setup", rd, 32'h8);
        pin_in = NP'(32'h0010_0821);           // fall on pin 3, at negedge
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_addr = A_STAT; bus_we = 1'b1; bus_wdata = 32'h8;
        @(posedge clk);                         // event and clear together
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
        bus_read(A_STAT, rd); check("R8 event survives clear", rd, 32'h8);
        bus_write(A_STAT, 32'h8);
        bus_read(A_STAT, rd); check("R8 later clear", rd, 0);

        // R10: spare storage
        bus_write(A_DIR, 32'h0000_00FF);
        bus_write(A_SPARE, 32'hDEAD_BEEF);
        bus_read(A_SPARE, rd); check("R10 readback", rd, 32'hDEAD_BEEF);
        check("R10 no pin effect", {4'd0, pin_oe}, 32'h0000_00FF);
        check("R10 no latch effect", {4'd0, pin_out}, {4'd0, lat});
        bus_read(A_STAT, rd); check("R10 no status effect", rd, 0);

        // R11: misaligned access
        bus_write(5'h05, 32'h0FFF_FFFF);
        bus_read(A_DIR, rd); check("R11 misaligned write ignored", rd, 32'h0000_00FF);
        bus_read(5'h1D, rd); check("R11 misaligned read zero", rd, 0);
        bus_write(5'h0B, 32'h0FFF_FFFF);
        check("R11 misaligned set ignored", {4'd0, pin_out}, {4'd0, lat});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule